// File: doc/BRIEF.md
# DLL Enable and Lock Sequencer

This controller decides when an output-timing delay-locked loop may run, follows its progress toward lock, and forces a clean restart when the input clock changes frequency. It runs on a free-running reference clock. It watches the input clock as a sampled signal, together with a reset pin, an enable pin, a flag that reports whether the input clock period is within range, and a request that announces a new nominal frequency.

While every enabling condition holds, the block raises `dll_enable` and counts rising edges of the input clock. Once it has counted the full lock interval it raises `locked`. Any disabling condition pulls both outputs low and clears the count. The disabling conditions are a reset, a low enable pin, an out-of-range period, or an input clock that has gone quiet for 30 ns of reference time. A frequency-change request produces a short enforced disable, so the loop always restarts its lock interval from zero and never relocks silently.

Top module: `dll_lock_seq`

## Requirements
- R1: `dll_enable` is high only while the synchronized reset is low, `dll_pin` is high, `period_ok` is high, the input clock is active and no frequency change is pending. With `period_ok` low, `dll_enable` stays low even when all other conditions are met.
- R2: While enabled, each rising edge of `ck_in` seen in the reference domain increments `lock_count`. `locked` goes high when `lock_count` reaches LOCK_CYCLES (default 65,536) and is low before that.
- R3: When `lock_count` reaches LOCK_CYCLES it saturates there, and `locked` stays high for as long as the block stays enabled.
- R4: A high level on `rst` clears `dll_enable`, `locked` and `lock_count` at once, without waiting for a clock edge.
- R5: When `dll_pin` or `period_ok` falls, `dll_enable`, `locked` and `lock_count` are still unchanged after the second reference edge. All three read 0 after the third reference edge, because of the two-flop synchronizer plus one register.
- R6: If no `ck_in` rising edge is seen for TIMEOUT reference cycles, where TIMEOUT = ceil(30000 / REF_PERIOD_PS), the block disables and clears the lock. When the clock stops, the block does not disable within 4 reference cycles, since a clock can look quiet for up to that long after its last edge. The lock sequence restarts when the clock resumes.
- R7: A rising edge on `freq_change` is first visible after the third reference edge. `dll_enable` reads low after the fourth and fifth edges and high again after the sixth, with `lock_count` at 0. A full new lock interval then follows.
- R8: `lock_count` reads 0 whenever `dll_enable` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Reset pin, active high, asynchronous assert |
| dll_pin | input | 1 | External enable pin, high to allow the loop |
| ck_in | input | 1 | Input clock, sampled as data |
| period_ok | input | 1 | High while the input clock period is within the allowed maximum |
| freq_change | input | 1 | Rising edge announces a new nominal frequency |
| dll_enable | output | 1 | Loop enable |
| locked | output | 1 | Lock declared |
| lock_count | output | CNT_W | Input-clock edges counted since enable, saturating at LOCK_CYCLES |

## Verification
A stuck or mis-cleared lock counter shows at the ports on the next reference edge: `lock_count` is nonzero while `dll_enable` is low, or it keeps climbing past the lock limit. A wrong enable decision shows as `dll_enable` failing to fall exactly three edges after a pin or period change, or failing to take the two-cycle dip after a frequency request. A faulty stop watchdog shows either as an early disable within the first few quiet cycles or as the loop staying enabled a dozen cycles after the clock has stopped.

// File: rtl/dll_seq_pkg.sv
package dll_seq_pkg;
  localparam int STOP_LIMIT_PS = 30000;

  // reference ticks that cover the clock-stop interval, rounded up
  function automatic int timeout_ticks(input int ref_ps);
    return (STOP_LIMIT_PS + ref_ps - 1) / ref_ps;
  endfunction

  // bits needed to hold 0..n
  function automatic int cnt_width(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/dll_sync2.sv
module dll_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/dll_clk_watch.sv
module dll_clk_watch
  import dll_seq_pkg::*;
#(
  parameter int TIMEOUT = 4,
  localparam int TO_W = cnt_width(TIMEOUT)
) (
  input  logic clk,
  input  logic rst,
  input  logic ck_in,
  output logic ck_edge,
  output logic ck_alive
);
  logic            ck_s;
  logic            ck_d;
  logic [TO_W-1:0] quiet_cnt;

  dll_sync2 #(.W(1)) i_ck_sync (
    .clk(clk), .rst(rst), .d(ck_in), .q(ck_s)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst) ck_d <= 1'b0;
    else     ck_d <= ck_s;
  end

  assign ck_edge = ck_s & ~ck_d;

  // ticks since the last seen rising edge, parked at TIMEOUT when quiet
  always_ff @(posedge clk or posedge rst) begin
    if (rst)                                quiet_cnt <= TO_W'(TIMEOUT);
    else if (ck_edge)                       quiet_cnt <= '0;
    else if (quiet_cnt != TO_W'(TIMEOUT))   quiet_cnt <= quiet_cnt + 1'b1;
  end

  assign ck_alive = (quiet_cnt < TO_W'(TIMEOUT));

  // R6
  edge_revives_chk: assert property (@(posedge clk) disable iff (rst)
    ck_edge |=> ck_alive);

  // R6
  quiet_bound_chk: assert property (@(posedge clk) disable iff (rst)
    quiet_cnt <= TO_W'(TIMEOUT));
endmodule

// File: rtl/dll_lock_cnt.sv
module dll_lock_cnt #(
  parameter int LIMIT = 65536,
  parameter int CW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  output logic [CW-1:0] cnt,
  output logic          sat
);
  assign sat = (cnt == CW'(LIMIT));

  always_ff @(posedge clk or posedge rst) begin
    if (rst)               cnt <= '0;
    else if (clr)          cnt <= '0;
    else if (step && !sat) cnt <= cnt + 1'b1;
  end

  // R2
  lock_on_last_step_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sat) |-> ($past(cnt) == CW'(LIMIT - 1)));

  // R3
  saturate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sat && !clr) |=> sat);
endmodule

// File: rtl/dll_lock_seq.sv
module dll_lock_seq
  import dll_seq_pkg::*;
#(
  parameter int LOCK_CYCLES = 65536,
  parameter int REF_PERIOD_PS = 8000,
  localparam int CNT_W = cnt_width(LOCK_CYCLES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dll_pin,
  input  logic             ck_in,
  input  logic             period_ok,
  input  logic             freq_change,
  output logic             dll_enable,
  output logic             locked,
  output logic [CNT_W-1:0] lock_count
);
  localparam int TIMEOUT = timeout_ticks(REF_PERIOD_PS);

  logic [1:0] rst_q;
  logic       rst_s;
  logic       dll_s, per_s, fc_s;
  logic       fc_q;
  logic       fc_rise;
  logic       pend;
  logic       ck_edge, ck_alive;
  logic       enable_cond;
  logic       en_q;
  logic       sat;

  // reset pin: asynchronous assert, two-flop release
  always_ff @(posedge clk or posedge rst) begin
    if (rst) rst_q <= 2'b11;
    else     rst_q <= {rst_q[0], 1'b0};
  end
  assign rst_s = rst_q[1];

  dll_sync2 #(.W(3)) i_pin_sync (
    .clk(clk), .rst(rst),
    .d({dll_pin, period_ok, freq_change}),
    .q({dll_s, per_s, fc_s})
  );

  dll_clk_watch #(.TIMEOUT(TIMEOUT)) i_watch (
    .clk(clk), .rst(rst), .ck_in(ck_in),
    .ck_edge(ck_edge), .ck_alive(ck_alive)
  );

  // frequency change: pending until one cycle spent disabled
  always_ff @(posedge clk or posedge rst) begin
    if (rst) fc_q <= 1'b0;
    else     fc_q <= fc_s;
  end
  assign fc_rise = fc_s & ~fc_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)                pend <= 1'b0;
    else if (fc_rise)       pend <= 1'b1;
    else if (pend && !en_q) pend <= 1'b0;
  end

  assign enable_cond = !rst_s && dll_s && per_s && ck_alive && !pend;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= enable_cond;
  end

  dll_lock_cnt #(.LIMIT(LOCK_CYCLES), .CW(CNT_W)) i_cnt (
    .clk(clk), .rst(rst),
    .clr(!enable_cond),
    .step(ck_edge & en_q),
    .cnt(lock_count),
    .sat(sat)
  );

  assign dll_enable = en_q;
  assign locked     = en_q & sat;

  // R8
  count_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !dll_enable |-> (lock_count == '0));

  // R5
  pin_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dll_s) |=> !dll_enable);

  // R7
  freq_disable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pend) |=> !dll_enable);

  // R6
  stop_disable_chk: assert property (@(posedge clk) disable iff (rst)
    !ck_alive |=> !dll_enable);
endmodule

// File: tb/test_dll_lock_seq.sv
module test_dll_lock_seq;
  localparam int LOCK = 32;
  localparam int REF_PS = 8000;
  localparam int TO = (30000 + REF_PS - 1) / REF_PS;  // 4 ticks
  localparam int CW = $clog2(LOCK + 1);

  typedef struct {
    string      req;
    logic       en;
    logic       lk;
    logic       use_cnt;
    logic [CW-1:0] cnt;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dll_pin = 1'b1;
  logic ck_in = 1'b0;
  logic period_ok = 1'b0;
  logic freq_change = 1'b0;
  logic ck_run = 1'b1;
  logic dll_enable, locked;
  logic [CW-1:0] lock_count;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  exp_t q[$];

  dll_lock_seq #(.LOCK_CYCLES(LOCK), .REF_PERIOD_PS(REF_PS)) i_dll_lock_seq (
    .clk(clk), .rst(rst), .dll_pin(dll_pin), .ck_in(ck_in),
    .period_ok(period_ok), .freq_change(freq_change),
    .dll_enable(dll_enable), .locked(locked), .lock_count(lock_count)
  );

  always #4 clk = ~clk;

  // input clock: one toggle per reference cycle, rising edge every 2 cycles
  always @(negedge clk) if (ck_run) ck_in <= ~ck_in;

  function automatic void compare(exp_t e);
    n_chk++;
    if (dll_enable !== e.en || locked !== e.lk ||
        (e.use_cnt && lock_count !== e.cnt)) begin
      n_fail++;
      $display("FAIL %s: en/lk/cnt actual %b/%b/%0d expected %b/%b/%0d",
               e.req, dll_enable, locked, lock_count, e.en, e.lk,
               e.use_cnt ? int'(e.cnt) : -1);
    end
  endfunction

  // monitor: compares every item pushed during this cycle
  initial forever begin
    @(posedge clk);
    #4;
    while (q.size() > 0) compare(q.pop_front());
  end

  task automatic expect_after(input int edges, input string req, input logic en,
                              input logic lk, input logic uc, input int cnt);
    exp_t e;
    repeat (edges) @(posedge clk);
    #2;
    e.req = req; e.en = en; e.lk = lk; e.use_cnt = uc; e.cnt = CW'(cnt);
    q.push_back(e);
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    expect_after(5, "R4 reset state", 0, 0, 1, 0);
    @(negedge clk) rst = 1'b0;
    // R1: period out of range keeps the loop off
    expect_after(10, "R1 period gate", 0, 0, 1, 0);
    @(negedge clk) period_ok = 1'b1;
    expect_after(10, "R1 enable", 1, 0, 0, 0);
    // R2 / R3 lock and saturation
    expect_after(100, "R2 lock", 1, 1, 1, LOCK);
    expect_after(20, "R3 saturate", 1, 1, 1, LOCK);

    // R5 pin drop
    @(negedge clk) dll_pin = 1'b0;
    expect_after(2, "R5 pin not yet", 1, 1, 1, LOCK);
    expect_after(1, "R5 pin drop", 0, 0, 1, 0);
    expect_after(5, "R8 count held zero", 0, 0, 1, 0);
    @(negedge clk) dll_pin = 1'b1;
    expect_after(100, "R2 relock after pin", 1, 1, 1, LOCK);

    // R5 period drop
    @(negedge clk) period_ok = 1'b0;
    expect_after(2, "R5 period not yet", 1, 1, 1, LOCK);
    expect_after(1, "R5 period drop", 0, 0, 1, 0);
    @(negedge clk) period_ok = 1'b1;
    expect_after(100, "R2 relock after period", 1, 1, 1, LOCK);

    // R7 frequency change
    @(negedge clk) freq_change = 1'b1;
    expect_after(3, "R7 before dip", 1, 1, 1, LOCK);
    expect_after(1, "R7 dip first", 0, 0, 1, 0);
    expect_after(1, "R7 dip second", 0, 0, 1, 0);
    expect_after(1, "R7 re-enable", 1, 0, 1, 0);
    expect_after(100, "R7 relock", 1, 1, 1, LOCK);
    @(negedge clk) freq_change = 1'b0;
    expect_after(10, "R7 fall ignored", 1, 1, 1, LOCK);

    // R6 clock stop
    @(negedge clk) ck_run = 1'b0;
    expect_after(TO, "R6 no early stop", 1, 1, 1, LOCK);
    expect_after(8, "R6 stop disable", 0, 0, 1, 0);
    @(negedge clk) ck_run = 1'b1;
    expect_after(100, "R6 recover", 1, 1, 1, LOCK);

    // R4 asynchronous reset mid-cycle
    @(posedge clk);
    #3 rst = 1'b1;
    #1;
    begin
      exp_t e;
      e.req = "R4 async clear"; e.en = 0; e.lk = 0; e.use_cnt = 1; e.cnt = '0;
      compare(e);
    end
    expect_after(3, "R4 held in reset", 0, 0, 1, 0);
    @(posedge clk);
    #6;
    finish_run();
  end
endmodule